// File: doc/BRIEF.md
# Bi-Weighted Prediction Merge Datapath

This block merges two streams of signed 16-bit intermediate prediction samples into unsigned 8-bit pixels. Each beat carries four horizontally adjacent samples from each source. Every lane multiplies its first sample by a first weight and its second sample by a second weight. The lane adds the two products to a per-block constant, shifts the sum right arithmetically and clamps the result to a byte.

A start pulse captures the configuration: the two weights, two offsets, two level shifts, a shift amount and the block width and height. The block computes the constant once at that pulse. The constant holds both level-shift terms, both offsets and the rounding term. The block then accepts exactly the number of input beats the block size calls for. It emits the same number of output beats through a three-stage pipeline that stalls as a whole on output back-pressure. A one-cycle done pulse marks the end of each block.

Top module: `bipred_merge`

## Requirements
- R1: For each lane, the output byte is clamp(((a + lvlA)·wA + (b + lvlB)·wB + rnd) >>> shift). Here rnd = (offA + offB + 1) << (shift − 1). All arithmetic is 32-bit two's complement, and the constant uses the configuration captured at the accepted start pulse.
- R2: Changes on the configuration inputs after an accepted start have no effect on the pixels of the block in progress.
- R3: The right shift is arithmetic, and any lane whose shifted sum is negative outputs 0.
- R4: Any lane whose shifted sum is above 255 outputs 255. The value first saturates to 16 unsigned bits and then to 8 unsigned bits.
- R5: With a shift of 0 the rounding term is 0, so the lane outputs clamp(a·wA + b·wB + lvlA·wA + lvlB·wB).
- R6: Lane i takes bits [16i+15:16i] of each source bus and drives bits [8i+7:8i] of the pixel bus.
- R7: A block of width W and height H accepts exactly (W/4)·H input beats and emits exactly (W/4)·H output beats, in order. W and H are multiples of 4. inReady is low while idle and after the last input beat of a block.
- R8: A start pulse with width 0 or height 0 produces no beats. It raises done in the next cycle.
- R9: While outValid is high and outReady is low, outValid stays high and outPix holds its value in the next cycle.
- R10: done is high for exactly one cycle. That cycle directly follows the acceptance of the block's last output beat, and done is high at no other time except under R8.
- R11: A start pulse that arrives while a block is in progress is ignored.
- R12: During and directly after reset, inReady, outValid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block, capturing the configuration |
| cfgWgtA | input | 16 | Signed weight for source A |
| cfgWgtB | input | 16 | Signed weight for source B |
| cfgOffA | input | 16 | Signed offset A |
| cfgOffB | input | 16 | Signed offset B |
| cfgLvlA | input | 16 | Signed level shift for source A |
| cfgLvlB | input | 16 | Signed level shift for source B |
| cfgShift | input | 5 | Right-shift amount |
| cfgWidth | input | 12 | Block width in pixels |
| cfgHeight | input | 12 | Block height in rows |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inSrcA | input | 64 | Four signed source-A samples |
| inSrcB | input | 64 | Four signed source-B samples |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Consumer ready for the output beat |
| outPix | output | 32 | Four clamped pixels |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The bench builds the block with its default parameters: four lanes, 16-bit samples, 32-bit sums, 12-bit dimensions and a 5-bit shift. With these values the full clamp range can be reached from small sample ranges. A sample range of a few thousand combined with moderate weights drives lanes past both rails, while a zero shift turns the lane into a plain clamped sum. The 12-bit dimension counters make multi-group blocks short to run. Zero-size blocks and blocks of several row groups in both directions exercise the counter wrap that ends each block.

// File: rtl/bipred_pkg.sv
package bipred_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic loadCfg;   // capture configuration and constant
    logic accept;    // an input beat enters stage 1
    logic lastBeat;  // the accepted beat is the block's final one
  } ctrlStrobe_t;

endpackage

// File: rtl/bipred_ctrl.sv
module bipred_ctrl
  import bipred_pkg::*;
#(
  parameter int DIM_W   = 12,
  parameter int LANES   = 4,
  parameter int ROW_GRP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] cfgWidth,
  input  logic [DIM_W-1:0] cfgHeight,
  input  logic             inValid,
  input  logic             pipeAdvance,
  input  logic             lastOutFire,
  output logic             inReady,
  output logic             done,
  output ctrlStrobe_t      strobes
);

  localparam int RW = (ROW_GRP > 1) ? $clog2(ROW_GRP) : 1;
  localparam logic [RW-1:0]    ROW_LAST = RW'(ROW_GRP - 1);
  localparam logic [DIM_W-1:0] COL_STEP = DIM_W'(LANES);
  localparam logic [DIM_W-1:0] ROW_STEP = DIM_W'(ROW_GRP);

  logic             busy;
  logic             allIn;
  logic [RW-1:0]    rowIdx;
  logic [DIM_W-1:0] colLeft;
  logic [DIM_W-1:0] htLeft;
  logic [DIM_W-1:0] widthReg;
  logic             zeroDim;
  logic             launch;
  logic             acc;
  logic             lastBeat;

  always_comb begin
    zeroDim  = (cfgWidth == '0) || (cfgHeight == '0);
    launch   = start && !busy;
    inReady  = busy && !allIn && pipeAdvance;
    acc      = inValid && inReady;
    lastBeat = (rowIdx == ROW_LAST) && (colLeft == COL_STEP) && (htLeft == ROW_STEP);
    strobes.loadCfg  = launch && !zeroDim;
    strobes.accept   = acc;
    strobes.lastBeat = lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      allIn    <= 1'b0;
      rowIdx   <= '0;
      colLeft  <= '0;
      htLeft   <= '0;
      widthReg <= '0;
      done     <= 1'b0;
    end else begin
      done <= (launch && zeroDim) || lastOutFire;
      if (launch && !zeroDim) begin
        busy     <= 1'b1;
        allIn    <= 1'b0;
        rowIdx   <= '0;
        colLeft  <= cfgWidth;
        htLeft   <= cfgHeight;
        widthReg <= cfgWidth;
      end else begin
        if (acc) begin
          if (lastBeat) allIn <= 1'b1;
          if (rowIdx == ROW_LAST) begin
            rowIdx <= '0;
            if (colLeft == COL_STEP) begin
              colLeft <= widthReg;
              htLeft  <= htLeft - ROW_STEP;
            end else begin
              colLeft <= colLeft - COL_STEP;
            end
          end else begin
            rowIdx <= rowIdx + 1'b1;
          end
        end
        if (lastOutFire) busy <= 1'b0;
      end
    end
  end

  // R8: an empty block finishes at once and opens no input window
  p_zero_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zeroDim) |=> (done && !inReady));

  // R10: done never stretches unless a fresh empty block restarts it
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

endmodule

// File: rtl/bipred_datapath.sv
module bipred_datapath
  import bipred_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SAMP_W  = 16,
  parameter int ACC_W   = 32,
  parameter int MID_W   = 16,
  parameter int PIX_W   = 8,
  parameter int SHIFT_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobe_t                strobes,
  input  logic signed [SAMP_W-1:0]   cfgWgtA,
  input  logic signed [SAMP_W-1:0]   cfgWgtB,
  input  logic signed [SAMP_W-1:0]   cfgOffA,
  input  logic signed [SAMP_W-1:0]   cfgOffB,
  input  logic signed [SAMP_W-1:0]   cfgLvlA,
  input  logic signed [SAMP_W-1:0]   cfgLvlB,
  input  logic [SHIFT_W-1:0]         cfgShift,
  input  logic [LANES*SAMP_W-1:0]    inSrcA,
  input  logic [LANES*SAMP_W-1:0]    inSrcB,
  input  logic                       outReady,
  output logic                       pipeAdvance,
  output logic                       outValid,
  output logic                       outLast,
  output logic [LANES*PIX_W-1:0]     outPix
);

  localparam int PROD_W = 2 * SAMP_W;

  // Configuration captured at start
  logic signed [SAMP_W-1:0] wgtAR, wgtBR;
  logic [SHIFT_W-1:0]       shiftR;
  logic signed [ACC_W-1:0]  constR;

  // Per-block constant from the raw configuration
  logic signed [ACC_W-1:0] lvlAx, lvlBx, wAx, wBx, offAx, offBx, offSum, rndTerm, constNext;

  always_comb begin
    lvlAx     = ACC_W'(cfgLvlA);
    lvlBx     = ACC_W'(cfgLvlB);
    wAx       = ACC_W'(cfgWgtA);
    wBx       = ACC_W'(cfgWgtB);
    offAx     = ACC_W'(cfgOffA);
    offBx     = ACC_W'(cfgOffB);
    offSum    = offAx + offBx + ACC_W'(1);
    rndTerm   = (cfgShift == '0) ? '0 : (offSum <<< (cfgShift - SHIFT_W'(1)));
    constNext = lvlAx * wAx + lvlBx * wBx + rndTerm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wgtAR  <= '0;
      wgtBR  <= '0;
      shiftR <= '0;
      constR <= '0;
    end else if (strobes.loadCfg) begin
      wgtAR  <= cfgWgtA;
      wgtBR  <= cfgWgtB;
      shiftR <= cfgShift;
      constR <= constNext;
    end
  end

  // Stage valid flags; the whole pipe moves together
  logic v1, v2, v3, last1, last2, last3;

  assign pipeAdvance = !v3 || outReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      last1 <= 1'b0; last2 <= 1'b0; last3 <= 1'b0;
    end else if (pipeAdvance) begin
      v1    <= strobes.accept;
      last1 <= strobes.accept && strobes.lastBeat;
      v2    <= v1;
      last2 <= last1;
      v3    <= v2;
      last3 <= last2;
    end
  end

  logic [LANES*PIX_W-1:0] pixAll;
  logic [LANES-1:0]       laneNeg;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [SAMP_W-1:0] sA, sB;
    logic signed [PROD_W-1:0] prodA, prodB;
    logic signed [ACC_W-1:0]  sumR, shifted;
    logic [MID_W-1:0]         mid;
    logic [PIX_W-1:0]         pix;

    assign sA = inSrcA[l*SAMP_W +: SAMP_W];
    assign sB = inSrcB[l*SAMP_W +: SAMP_W];

    // Stage 1: products
    always_ff @(posedge clk) begin
      if (pipeAdvance && strobes.accept) begin
        prodA <= sA * wgtAR;
        prodB <= sB * wgtBR;
      end
    end

    // Stage 2: sum of products plus block constant
    always_ff @(posedge clk) begin
      if (pipeAdvance && v1) begin
        sumR <= ACC_W'(prodA) + ACC_W'(prodB) + constR;
      end
    end

    // Stage 3 (combinational part): shift and two-step saturation
    always_comb begin
      shifted = sumR >>> shiftR;
      if (shifted[ACC_W-1])
        mid = '0;
      else if (|shifted[ACC_W-2:MID_W])
        mid = '1;
      else
        mid = shifted[MID_W-1:0];
      if (|mid[MID_W-1:PIX_W])
        pix = '1;
      else
        pix = mid[PIX_W-1:0];
    end

    assign pixAll[l*PIX_W +: PIX_W] = pix;
    assign laneNeg[l]               = shifted[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (pipeAdvance && v2) outPix <= pixAll;
  end

  assign outValid = v3;
  assign outLast  = last3;

  // R9: a stalled beat is neither dropped nor altered
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outPix)));

  // R3: a negative shifted sum in lane 0 lands as a zero byte
  p_neg_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && pipeAdvance && laneNeg[0]) |=> (outPix[PIX_W-1:0] == '0));

endmodule

// File: rtl/bipred_merge.sv
module bipred_merge
  import bipred_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SAMP_W  = 16,
  parameter int ACC_W   = 32,
  parameter int MID_W   = 16,
  parameter int PIX_W   = 8,
  parameter int SHIFT_W = 5,
  parameter int DIM_W   = 12,
  parameter int ROW_GRP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [SAMP_W-1:0] cfgWgtA,
  input  logic signed [SAMP_W-1:0] cfgWgtB,
  input  logic signed [SAMP_W-1:0] cfgOffA,
  input  logic signed [SAMP_W-1:0] cfgOffB,
  input  logic signed [SAMP_W-1:0] cfgLvlA,
  input  logic signed [SAMP_W-1:0] cfgLvlB,
  input  logic [SHIFT_W-1:0]       cfgShift,
  input  logic [DIM_W-1:0]         cfgWidth,
  input  logic [DIM_W-1:0]         cfgHeight,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [LANES*SAMP_W-1:0]  inSrcA,
  input  logic [LANES*SAMP_W-1:0]  inSrcB,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [LANES*PIX_W-1:0]   outPix,
  output logic                     done
);

  ctrlStrobe_t strobes;
  logic        pipeAdvance;
  logic        outLast;
  logic        lastOutFire;

  assign lastOutFire = outValid && outReady && outLast;

  bipred_ctrl #(
    .DIM_W(DIM_W), .LANES(LANES), .ROW_GRP(ROW_GRP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .inValid(inValid), .pipeAdvance(pipeAdvance), .lastOutFire(lastOutFire),
    .inReady(inReady), .done(done), .strobes(strobes)
  );

  bipred_datapath #(
    .LANES(LANES), .SAMP_W(SAMP_W), .ACC_W(ACC_W),
    .MID_W(MID_W), .PIX_W(PIX_W), .SHIFT_W(SHIFT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .cfgWgtA(cfgWgtA), .cfgWgtB(cfgWgtB),
    .cfgOffA(cfgOffA), .cfgOffB(cfgOffB),
    .cfgLvlA(cfgLvlA), .cfgLvlB(cfgLvlB), .cfgShift(cfgShift),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .outReady(outReady),
    .pipeAdvance(pipeAdvance), .outValid(outValid),
    .outLast(outLast), .outPix(outPix)
  );

  // R10: when done rises the pipeline has drained completely
  p_drained_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !outValid);

endmodule

// File: tb/tb_bipred_merge.sv
module tb_bipred_merge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic signed [15:0] cfgWgtA = '0, cfgWgtB = '0, cfgOffA = '0, cfgOffB = '0;
  logic signed [15:0] cfgLvlA = '0, cfgLvlB = '0;
  logic [4:0]  cfgShift = '0;
  logic [11:0] cfgWidth = '0, cfgHeight = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inSrcA = '0, inSrcB = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outPix;
  logic        done;

  always #2 clk = ~clk;  // 250 MHz

  bipred_merge dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfgWgtA(cfgWgtA), .cfgWgtB(cfgWgtB), .cfgOffA(cfgOffA), .cfgOffB(cfgOffB),
    .cfgLvlA(cfgLvlA), .cfgLvlB(cfgLvlB), .cfgShift(cfgShift),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .inValid(inValid), .inReady(inReady), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .outValid(outValid), .outReady(outReady), .outPix(outPix), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model state
  int  mWA, mWB, mSh, mK;
  bit  busyM = 0;
  int  totalM = 0, inAcc = 0, outCnt = 0;
  int  blkBeats = -1;
  bit  expDone = 0;
  bit  stallPrev = 0;
  logic [31:0] stallPix;
  logic [31:0] expQ[$];
  string curTag = "R1";

  function automatic logic [31:0] refPix(input logic [63:0] a, input logic [63:0] b);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      int s;
      s = int'($signed(a[16*l +: 16])) * mWA + int'($signed(b[16*l +: 16])) * mWB + mK;
      s = s >>> mSh;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      r[8*l +: 8] = s[7:0];
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit expDoneNext;
      expDoneNext = 0;
      chk(done == expDone, "R10 done timing", {31'b0, done}, {31'b0, expDone});
      if (!busyM || inAcc == totalM)
        chk(!inReady, "R7 inReady outside window", {31'b0, inReady}, 32'd0);
      if (stallPrev)
        chk(outValid && outPix == stallPix, "R9 stall hold", outPix, stallPix);
      if (start && !busyM) begin
        if (cfgWidth == 0 || cfgHeight == 0) begin
          expDoneNext = 1;
          blkBeats = 0;
        end else begin
          mWA = int'(cfgWgtA); mWB = int'(cfgWgtB); mSh = int'(cfgShift);
          mK = int'(cfgLvlA) * mWA + int'(cfgLvlB) * mWB +
               ((mSh == 0) ? 0 : ((int'(cfgOffA) + int'(cfgOffB) + 1) <<< (mSh - 1)));
          busyM = 1; totalM = (int'(cfgWidth) / 4) * int'(cfgHeight);
          inAcc = 0; outCnt = 0;
        end
      end
      if (inValid && inReady) begin
        expQ.push_back(refPix(inSrcA, inSrcB));
        inAcc++;
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(0, "R7 unexpected output beat", outPix, 32'd0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk(outPix == e, curTag, outPix, e);
        end
        outCnt++;
        if (busyM && outCnt == totalM) begin
          expDoneNext = 1;
          busyM = 0;
          blkBeats = outCnt;
        end
      end
      stallPrev = outValid && !outReady;
      stallPix  = outPix;
      expDone   = expDoneNext;
    end
  end

  always @(posedge clk) begin
    #1 outReady <= ($urandom % 4) != 0;
  end

  task automatic runBlock(input int w, input int h, input int wa, input int wb,
                          input int oa, input int ob, input int sh, input int la, input int lb,
                          input int lo, input int hi, input string tag, input bit poke);
    int total;
    curTag = tag;
    blkBeats = -1;
    cfgWidth = 12'(w); cfgHeight = 12'(h);
    cfgWgtA = 16'(wa); cfgWgtB = 16'(wb); cfgOffA = 16'(oa); cfgOffB = 16'(ob);
    cfgShift = 5'(sh); cfgLvlA = 16'(la); cfgLvlB = 16'(lb);
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    total = (w / 4) * h;
    for (int n = 0; n < total; n++) begin
      if ($urandom % 3 == 0) begin @(posedge clk); #1; end
      inValid = 1'b1;
      for (int l = 0; l < 4; l++) begin
        inSrcA[16*l +: 16] = 16'(lo + int'($urandom % (hi - lo + 1)));
        inSrcB[16*l +: 16] = 16'(lo + int'($urandom % (hi - lo + 1)));
      end
      if (poke && n == 1) begin
        // R11: start mid-block with new size; R2: new config values
        start = 1'b1; cfgWidth = 12'd4; cfgHeight = 12'd4;
        cfgWgtA = 16'sd7; cfgWgtB = -16'sd3; cfgShift = 5'd2; cfgOffA = 16'sd99;
        cfgLvlA = 16'sd50;
      end
      do @(negedge clk); while (!inReady);
      @(posedge clk); #1;
      inValid = 1'b0;
      start = 1'b0;
    end
    while (blkBeats < 0) @(negedge clk);
    chk(blkBeats == total, (total == 0) ? "R8 beat count" : "R7 beat count",
        32'(blkBeats), 32'(total));
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!inReady && !outValid && !done, "R12 reset state",
        {29'b0, inReady, outValid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!inReady && !outValid && !done, "R12 after reset",
        {29'b0, inReady, outValid, done}, 32'd0);
    @(posedge clk); #1;
    runBlock(8, 8, 3, 5, 2, -1, 9, 16, -8, -2000, 12000, "R1 R6 pixel", 0);
    runBlock(4, 8, -20, 40, 100, 50, 4, 0, 0, -3000, 3000, "R3 R4 clamp", 0);
    runBlock(12, 4, 1, 1, 7, 9, 0, 0, 0, -50, 200, "R5 zero shift", 0);
    runBlock(0, 8, 1, 1, 0, 0, 3, 0, 0, 0, 10, "R8 zero width", 0);
    runBlock(8, 0, 1, 1, 0, 0, 3, 0, 0, 0, 10, "R8 zero height", 0);
    runBlock(8, 4, 11, -6, -40, 20, 6, 30, -12, -4000, 9000, "R2 R11 ignore", 1);
    runBlock(16, 12, 64, 64, 0, 0, 7, 0, 0, -1000, 9000, "R1 R7 large", 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule